// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the access address for short bursts of up to four beats. A single control pin does two jobs. When it is low on an enabled clock edge, the block loads a new start address. It also latches the access direction (read or write) and the order mode. When the pin is high, the block advances the beat counter of the current burst. Only the two lowest address bits move, in linear order (start plus beat, modulo 4) or interleaved order (start XOR beat), and they wrap after the fourth beat. The upper address bits keep the loaded value.

An active-low clock enable freezes the whole block. A load taken while the select input is low is a deselect: it ends the burst and leaves the address and direction as they were. Advancing does not look at the select or write-enable inputs. The direction stays frozen for the whole burst. An advance with no burst in progress does nothing.

The controller has two states. In `ST_IDLE` no burst is active. In `ST_BURST` a burst is in progress. The transitions are:
- `LOAD_SEL` goes from idle or burst to `ST_BURST`.
- `RELOAD` is a load taken while already in `ST_BURST`; it stays in `ST_BURST`.
- `STEP` is an advance taken in burst; it stays in `ST_BURST`.
- `DESELECT` goes from either state to `ST_IDLE`.
- `NOP` is an advance taken in idle; it stays in `ST_IDLE`.
- `HOLD` is any edge with the clock enable high; the state does not change.

Top module: `bseq_top`

## Requirements
- R1: After reset, `addr_out` is 0, `dir_wr` is 0 and `burst_active` is 0.
- R2: An enabled edge with `ld_adv_n`=0 and `sel`=1 loads a burst. From the next cycle, `addr_out` equals `addr_in`, `dir_wr` equals the inverse of `wr_n` (1 means write), and `burst_active` is 1.
- R3: With `mode`=0 latched at load, after n advances address bits [1:0] equal (start[1:0] + n) mod 4.
- R4: With `mode`=1 latched at load, after n advances address bits [1:0] equal start[1:0] XOR (n mod 4).
- R5: The beat count wraps, so the fourth advance returns bits [1:0] to the start value. Address bits above bit 1 never change during a burst.
- R6: An advance ignores `sel` and `wr_n`, and `dir_wr` keeps the value latched at load.
- R7: An enabled edge with `ld_adv_n`=0 and `sel`=0 clears `burst_active` and leaves `addr_out` and `dir_wr` unchanged.
- R8: An advance while `burst_active` is 0 leaves `addr_out` unchanged and `burst_active` at 0.
- R9: While `clk_en_n`=1, `addr_out`, `dir_wr` and `burst_active` hold, whatever the other inputs do.
- R10: A selected load during an active burst restarts from the new address at beat 0.
- R11: `mode` is sampled only at load, so a change of `mode` during a burst does not alter the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| ld_adv_n | input | 1 | 0 = load start address, 1 = advance burst |
| sel | input | 1 | Combined chip select, active high, used only on load |
| wr_n | input | 1 | Write enable, active low, sampled only on load |
| mode | input | 1 | 0 = linear order, 1 = interleaved, sampled on load |
| addr_in | input | ADDR_W | Start address |
| addr_out | output | ADDR_W | Current access address |
| dir_wr | output | 1 | Latched direction, 1 = write |
| burst_active | output | 1 | A burst is in progress |

## Verification
Two functions can fall in the same cycle: the clock-enable freeze and a load or advance request. The bench drives `clk_en_n` high together with `ld_adv_n` low and a new address, and also together with advance requests in mid-burst. It expects the outputs of the previous cycle unchanged. Randomly mixed cycles also combine a reload with an active burst and toggle `sel` or `wr_n` during advances. A bench model judges every cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bseq_state_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_LOAD,
        OP_DESEL,
        OP_STEP,
        OP_NOP
    } bseq_op_e;
endpackage

// File: rtl/bseq_order.sv
module bseq_order
    import bseq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [BEAT_W-1:0] addr_lo
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    always_comb begin
        lin_lo = start_lo + beat;
    end

    genvar b;
    generate
        for (b = 0; b < BEAT_W; b++) begin : g_ilv
            assign ilv_lo[b] = start_lo[b] ^ beat[b];
        end
    endgenerate

    always_comb begin
        addr_lo = interleave ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              ld_adv_n,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] start_q,
    output logic [BEAT_W-1:0] beat_q,
    output logic              mode_q,
    output logic              dir_q,
    output logic              active
);
    bseq_state_e state_q, state_d;
    bseq_op_e    op;

    always_comb begin
        if (clk_en_n)
            op = OP_HOLD;
        else if (!ld_adv_n)
            op = sel ? OP_LOAD : OP_DESEL;
        else if (state_q == ST_BURST)
            op = OP_STEP;
        else
            op = OP_NOP;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op == OP_LOAD) state_d = ST_BURST;    // LOAD_SEL
            end
            ST_BURST: begin
                if (op == OP_DESEL) state_d = ST_IDLE;    // DESELECT
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
            mode_q  <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    start_q <= addr_in;
                    beat_q  <= '0;
                    mode_q  <= mode;
                    dir_q   <= ~wr_n;
                end
                OP_STEP: beat_q <= beat_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign active = (state_q == ST_BURST);

    assert_idle_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && ld_adv_n && !active) |=> (!active && $stable(beat_q) && $stable(start_q)));

    assert_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !ld_adv_n && !sel) |=> (!active && $stable(start_q) && $stable(dir_q) && $stable(beat_q)));

    assert_step_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && ld_adv_n && active) |=> (active && $stable(dir_q) && $stable(mode_q) && $stable(start_q)));
endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              ld_adv_n,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              dir_wr,
    output logic              burst_active
);
    logic [ADDR_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    logic              mode_q;
    logic [BEAT_W-1:0] lo;

    bseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .ld_adv_n (ld_adv_n),
        .sel      (sel),
        .wr_n     (wr_n),
        .mode     (mode),
        .addr_in  (addr_in),
        .start_q  (start_q),
        .beat_q   (beat_q),
        .mode_q   (mode_q),
        .dir_q    (dir_wr),
        .active   (burst_active)
    );

    bseq_order u_order (
        .start_lo   (start_q[BEAT_W-1:0]),
        .beat       (beat_q),
        .interleave (mode_q),
        .addr_lo    (lo)
    );

    assign addr_out = {start_q[ADDR_W-1:BEAT_W], lo};

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(addr_out) && $stable(dir_wr) && $stable(burst_active)));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !ld_adv_n && sel) |=>
        (burst_active && addr_out == $past(addr_in) && dir_wr == !$past(wr_n)));

    assert_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && ld_adv_n) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/sim_bseq_top.sv
module sim_bseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b1;
    logic        ld_adv_n = 1'b1;
    logic        sel = 1'b0;
    logic        wr_n = 1'b1;
    logic        mode = 1'b0;
    logic [15:0] addr_in = '0;
    logic [15:0] addr_out;
    logic        dir_wr;
    logic        burst_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic        m_act = 0;
    logic [15:0] m_start = '0;
    logic [1:0]  m_beat = '0;
    logic        m_mode = 0;
    logic        m_dir = 0;

    always #5 clk = ~clk;

    bseq_top #(.ADDR_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ld_adv_n(ld_adv_n),
        .sel(sel), .wr_n(wr_n), .mode(mode), .addr_in(addr_in),
        .addr_out(addr_out), .dir_wr(dir_wr), .burst_active(burst_active)
    );

    function automatic logic [15:0] exp_addr();
        logic [1:0] lo;
        lo = m_mode ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
        return {m_start[15:2], lo};
    endfunction

    task automatic check(input string tag);
        logic [15:0] ea;
        ea = exp_addr();
        n_chk++;
        if (addr_out !== ea || dir_wr !== m_dir || burst_active !== m_act) begin
            n_bad++;
            $display("FAIL %s: addr=%h dir=%b act=%b expected addr=%h dir=%b act=%b",
                     tag, addr_out, dir_wr, burst_active, ea, m_dir, m_act);
        end
    endtask

    task automatic step(input logic cen, input logic ld, input logic s, input logic w,
                        input logic m, input logic [15:0] a, input string tag);
        clk_en_n = cen; ld_adv_n = ld; sel = s; wr_n = w; mode = m; addr_in = a;
        @(posedge clk);
        if (!cen) begin
            if (!ld) begin
                if (s) begin
                    m_act = 1; m_start = a; m_beat = 0; m_mode = m; m_dir = !w;
                end else begin
                    m_act = 0;
                end
            end else if (m_act) begin
                m_beat = m_beat + 2'd1;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset");
        // R8: advance with nothing active
        step(0, 1, 1, 0, 0, 16'h5555, "R8 idle advance");
        // R2, R3, R5: linear from lo=2
        step(0, 0, 1, 1, 0, 16'h1232, "R2 load read");
        for (int i = 0; i < 5; i++) step(0, 1, 1, 1, 0, 16'h0000, "R3 linear step");
        // R6: advance with sel low and wr changed
        step(0, 1, 0, 0, 1, 16'hFFFF, "R6 advance ignores sel/wr");
        // R9: freeze while a load is requested
        step(1, 0, 1, 0, 1, 16'hBEEF, "R9 hold over load");
        step(1, 1, 1, 0, 1, 16'hBEEF, "R9 hold over advance");
        // R4, R5: interleaved from lo=1, write
        step(0, 0, 1, 0, 1, 16'hA5A1, "R2 load write");
        for (int i = 0; i < 5; i++) step(0, 1, 1, 1, 1, 16'h0000, "R4 interleave step");
        // R11: mode toggled mid burst
        step(0, 1, 1, 1, 0, 16'h0000, "R11 mode ignored mid burst");
        // R10: reload while active
        step(0, 0, 1, 1, 0, 16'h7773, "R10 reload");
        step(0, 1, 1, 1, 1, 16'h0000, "R10 step after reload");
        // R7: deselect then advance
        step(0, 0, 0, 0, 1, 16'h1111, "R7 deselect");
        step(0, 1, 1, 0, 0, 16'h2222, "R8 advance after deselect");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[2] | r[3], r[4] | r[5], r[6], r[7], r[31:16], "R3 R4 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule